// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code, an instruction operand and the
processor's base registers into a 24-bit effective address for a processor
with 16-bit offsets and an 8-bit bank byte. It covers seven modes: direct
page, direct page indexed, absolute, absolute indexed, absolute long, absolute
long indexed and stack relative. Direct page and stack accesses form a 16-bit
offset that wraps within bank 0. Absolute accesses take their bank from the
data bank input. Long accesses carry their own bank in the operand.

Alongside the address the block raises a flag that asks the sequencer for one
extra cycle. The flag is set when a direct page access uses a base that is not
page aligned. The index is taken from X or Y, either at full 16-bit width or
narrowed to its low byte. The result is registered, so it appears one clock
after the inputs are presented. Pointer fetches and bus timing belong to
other blocks.

Top module: `bank_ea_gen`

## Requirements
- R1: Mode code 0 (direct page) gives address {8'h00, (dp_i + operand_i[7:0]) mod 2^16}.
- R2: Mode code 1 (direct page indexed) gives {8'h00, (dp_i + operand_i[7:0] + index) mod 2^16}, where index is defined by R9.
- R3: extra_cyc_o is 1 exactly when the mode code is 0 or 1 and dp_i[7:0] is nonzero. For every other mode code it is 0, whatever dp_i holds.
- R4: Mode code 2 (absolute) gives {dbr_i, operand_i[15:0]}. operand_i[23:16] has no effect on the result.
- R5: Mode code 3 (absolute indexed) gives ({dbr_i, operand_i[15:0]} + index) mod 2^24. A carry out of bit 15 increments the bank byte.
- R6: Mode code 4 (absolute long) gives operand_i[23:0] unchanged.
- R7: Mode code 5 (absolute long indexed) gives (operand_i + index) mod 2^24.
- R8: Mode code 6 (stack relative) gives {8'h00, (sp_i + operand_i[7:0]) mod 2^16}.
- R9: The index is y_reg_i when use_y_i is 1 and x_reg_i when it is 0. When idx_wide_i is 0 only its low 8 bits are used, zero-extended. When idx_wide_i is 1 all 16 bits are used.
- R10: The outputs are registered. The values seen after a rising edge are computed from the inputs at that edge and hold until the next edge. An active-low reset sets ea_o to 0 and extra_cyc_o to 0. Mode code 7 is reserved and gives ea_o = 0 and extra_cyc_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Addressing-mode code (0..7) |
| use_y_i | input | 1 | Selects Y as the index when 1, X when 0 |
| idx_wide_i | input | 1 | 1: 16-bit index, 0: low byte of the index only |
| operand_i | input | 24 | Instruction operand (8, 16 or 24 bits used) |
| x_reg_i | input | 16 | X index register |
| y_reg_i | input | 16 | Y index register |
| sp_i | input | 16 | Stack pointer |
| dp_i | input | 16 | Direct page base |
| dbr_i | input | 8 | Data bank register |
| ea_o | output | 24 | Registered effective address |
| extra_cyc_o | output | 1 | Registered request for one extra cycle |

## Verification
Fixed vectors target the points where a wrong adder width or a wrong bank
source would show. These are a direct page base near 0xFFFF that must wrap
inside bank 0, an absolute indexed sum that must carry into the bank byte, and
a long sum that must wrap at 2^24. Another group pairs the same index register
values with both index widths and both index sources, and sets the operand's
upper byte in absolute mode, so that narrowing, source selection and operand
masking each have a visible effect. Aligned and misaligned direct page bases
are tried under every mode code to separate the extra-cycle flag from the mode
decode. A long run of random codes and register values is then compared with
the behavioural model on every clock. Before each edge the bench also checks
that the registered output has not yet moved.

// File: rtl/bea_pkg.sv
package bea_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT     = 3'd0,
        AM_DIRECT_IDX = 3'd1,
        AM_ABS        = 3'd2,
        AM_ABS_IDX    = 3'd3,
        AM_LONG       = 3'd4,
        AM_LONG_IDX   = 3'd5,
        AM_STACK      = 3'd6,
        AM_RSVD       = 3'd7
    } amode_e;

endpackage

// File: rtl/bea_index_sel.sv
module bea_index_sel #(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [OFS_W-1:0] x_reg_i,
    input  logic [OFS_W-1:0] y_reg_i,
    input  logic             use_y_i,
    input  logic             wide_i,
    output logic [OFS_W-1:0] idx_o
);

    logic [OFS_W-1:0] src;

    assign src = use_y_i ? y_reg_i : x_reg_i;

    // Bits below SHORT_W always pass; upper bits pass only in wide mode.
    for (genvar b = 0; b < OFS_W; b++) begin : g_bit
        if (b < SHORT_W) begin : g_low
            assign idx_o[b] = src[b];
        end else begin : g_high
            assign idx_o[b] = src[b] & wide_i;
        end
    end

endmodule

// File: rtl/bea_sum_unit.sv
module bea_sum_unit
    import bea_pkg::*;
#(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned BANK_W  = 8,
    parameter int unsigned SHORT_W = 8,
    localparam int unsigned EA_W   = OFS_W + BANK_W
) (
    input  amode_e            mode_i,
    input  logic [EA_W-1:0]   operand_i,
    input  logic [OFS_W-1:0]  idx_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [OFS_W-1:0]  dp_i,
    input  logic [BANK_W-1:0] dbr_i,
    output logic [EA_W-1:0]   ea_o,
    output logic              extra_o
);

    localparam logic [BANK_W-1:0] BANK_ZERO = '0;

    logic [OFS_W-1:0] short_ext;
    logic [EA_W-1:0]  idx_ext;
    logic [EA_W-1:0]  abs_base;
    logic [OFS_W-1:0] dp_sum;
    logic [OFS_W-1:0] dpx_sum;
    logic [OFS_W-1:0] sp_sum;
    logic             dp_misaligned;

    assign short_ext     = {{(OFS_W-SHORT_W){1'b0}}, operand_i[SHORT_W-1:0]};
    assign idx_ext       = {BANK_ZERO, idx_i};
    assign abs_base      = {dbr_i, operand_i[OFS_W-1:0]};
    assign dp_sum        = dp_i + short_ext;
    assign dpx_sum       = dp_sum + idx_i;
    assign sp_sum        = sp_i + short_ext;
    assign dp_misaligned = |dp_i[SHORT_W-1:0];

    always_comb begin
        ea_o    = '0;
        extra_o = 1'b0;
        unique case (mode_i)
            AM_DIRECT: begin
                ea_o    = {BANK_ZERO, dp_sum};
                extra_o = dp_misaligned;
            end
            AM_DIRECT_IDX: begin
                ea_o    = {BANK_ZERO, dpx_sum};
                extra_o = dp_misaligned;
            end
            AM_ABS:      ea_o = abs_base;
            AM_ABS_IDX:  ea_o = abs_base + idx_ext;
            AM_LONG:     ea_o = operand_i;
            AM_LONG_IDX: ea_o = operand_i + idx_ext;
            AM_STACK:    ea_o = {BANK_ZERO, sp_sum};
            AM_RSVD: begin
                ea_o    = '0;
                extra_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
    import bea_pkg::*;
#(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned BANK_W  = 8,
    parameter int unsigned SHORT_W = 8,
    localparam int unsigned EA_W   = OFS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              use_y_i,
    input  logic              idx_wide_i,
    input  logic [EA_W-1:0]   operand_i,
    input  logic [OFS_W-1:0]  x_reg_i,
    input  logic [OFS_W-1:0]  y_reg_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [OFS_W-1:0]  dp_i,
    input  logic [BANK_W-1:0] dbr_i,
    output logic [EA_W-1:0]   ea_o,
    output logic              extra_cyc_o
);

    logic [OFS_W-1:0] idx;
    logic [EA_W-1:0]  ea_next;
    logic             extra_next;

    bea_index_sel #(
        .OFS_W   (OFS_W),
        .SHORT_W (SHORT_W)
    ) u_idx (
        .x_reg_i (x_reg_i),
        .y_reg_i (y_reg_i),
        .use_y_i (use_y_i),
        .wide_i  (idx_wide_i),
        .idx_o   (idx)
    );

    bea_sum_unit #(
        .OFS_W   (OFS_W),
        .BANK_W  (BANK_W),
        .SHORT_W (SHORT_W)
    ) u_sum (
        .mode_i    (amode_e'(mode_i)),
        .operand_i (operand_i),
        .idx_i     (idx),
        .sp_i      (sp_i),
        .dp_i      (dp_i),
        .dbr_i     (dbr_i),
        .ea_o      (ea_next),
        .extra_o   (extra_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_o        <= '0;
            extra_cyc_o <= 1'b0;
        end else begin
            ea_o        <= ea_next;
            extra_cyc_o <= extra_next;
        end
    end

endmodule

// File: rtl/bank_ea_gen_chk.sv
module bank_ea_gen_chk
    import bea_pkg::*;
#(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned BANK_W  = 8,
    parameter int unsigned SHORT_W = 8,
    localparam int unsigned EA_W   = OFS_W + BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic [EA_W-1:0]   operand_i,
    input logic [OFS_W-1:0]  sp_i,
    input logic [OFS_W-1:0]  dp_i,
    input logic [BANK_W-1:0] dbr_i,
    input logic [EA_W-1:0]   ea_o,
    input logic              extra_cyc_o
);

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_DP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_i) == AM_DIRECT) |->
        ea_o == {{BANK_W{1'b0}}, OFS_W'($past(dp_i) + OFS_W'($past(operand_i[SHORT_W-1:0])))}); // R1

    AST_DPX_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_i) == AM_DIRECT_IDX) |-> ea_o[EA_W-1:OFS_W] == '0); // R2

    AST_EXTRA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && extra_cyc_o) |->
        (($past(mode_i) == AM_DIRECT || $past(mode_i) == AM_DIRECT_IDX)
         && $past(dp_i[SHORT_W-1:0]) != '0)); // R3

    AST_ABS_CAT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_i) == AM_ABS) |->
        ea_o == {$past(dbr_i), $past(operand_i[OFS_W-1:0])}); // R4

    AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_i) == AM_LONG) |-> ea_o == $past(operand_i)); // R6

    AST_STACK_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_i) == AM_STACK) |->
        ea_o == {{BANK_W{1'b0}}, OFS_W'($past(sp_i) + OFS_W'($past(operand_i[SHORT_W-1:0])))}); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_i) == AM_RSVD) |-> (ea_o == '0 && !extra_cyc_o)); // R10

endmodule

bind bank_ea_gen bank_ea_gen_chk #(
    .OFS_W   (OFS_W),
    .BANK_W  (BANK_W),
    .SHORT_W (SHORT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .operand_i   (operand_i),
    .sp_i        (sp_i),
    .dp_i        (dp_i),
    .dbr_i       (dbr_i),
    .ea_o        (ea_o),
    .extra_cyc_o (extra_cyc_o)
);

// File: tb/sim_bank_ea_gen.sv
`timescale 1ns/1ps
module sim_bank_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = '0;
    logic        use_y_i = 1'b0;
    logic        idx_wide_i = 1'b0;
    logic [23:0] operand_i = '0;
    logic [15:0] x_reg_i = '0;
    logic [15:0] y_reg_i = '0;
    logic [15:0] sp_i = '0;
    logic [15:0] dp_i = '0;
    logic [7:0]  dbr_i = '0;
    logic [23:0] ea_o;
    logic        extra_cyc_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [23:0] prev_ea = '0;
    logic        prev_pen = 1'b0;

    always #5 clk = ~clk;

    bank_ea_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .use_y_i     (use_y_i),
        .idx_wide_i  (idx_wide_i),
        .operand_i   (operand_i),
        .x_reg_i     (x_reg_i),
        .y_reg_i     (y_reg_i),
        .sp_i        (sp_i),
        .dp_i        (dp_i),
        .dbr_i       (dbr_i),
        .ea_o        (ea_o),
        .extra_cyc_o (extra_cyc_o)
    );

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Behavioural model: returns {penalty, address}
    function automatic logic [24:0] model(input int m, input int unsigned op,
                                          input int unsigned x, input int unsigned y,
                                          input int unsigned sp, input int unsigned dp,
                                          input int unsigned dbr, input bit uy, input bit wd);
        int unsigned idx, a;
        bit pen;
        idx = uy ? y : x;
        if (!wd) idx = idx % 256;
        pen = (m == 0 || m == 1) && (dp % 256 != 0);
        case (m)
            0: a = (dp + op % 256) % 65536;
            1: a = (dp + op % 256 + idx) % 65536;
            2: a = dbr * 65536 + op % 65536;
            3: a = (dbr * 65536 + op % 65536 + idx) % 16777216;
            4: a = op % 16777216;
            5: a = (op + idx) % 16777216;
            6: a = (sp + op % 256) % 65536;
            default: a = 0;
        endcase
        return {pen, a[23:0]};
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic step(input int m, input logic [23:0] op, input logic [15:0] x,
                        input logic [15:0] y, input logic [15:0] sp, input logic [15:0] dp,
                        input logic [7:0] dbr, input bit uy, input bit wd, input string tag);
        logic [24:0] e;
        @(negedge clk);
        mode_i = m[2:0]; operand_i = op; x_reg_i = x; y_reg_i = y;
        sp_i = sp; dp_i = dp; dbr_i = dbr; use_y_i = uy; idx_wide_i = wd;
        #1;
        check("R10", ea_o, prev_ea);
        check("R10", {23'd0, extra_cyc_o}, {23'd0, prev_pen});
        e = model(m, op, x, y, sp, dp, dbr, uy, wd);
        @(posedge clk);
        #2;
        check(tag, ea_o, e[23:0]);
        check("R3", {23'd0, extra_cyc_o}, {23'd0, e[24]});
        prev_ea = e[23:0];
        prev_pen = e[24];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R10", ea_o, 24'h0);
        check("R10", {23'd0, extra_cyc_o}, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Direct page: aligned, misaligned, wrap inside bank 0
        step(0, 24'hAB0010, 16'h0, 16'h0, 16'h0, 16'h1200, 8'h7E, 0, 1, "R1");
        step(0, 24'h000020, 16'h0, 16'h0, 16'h0, 16'hFFF0, 8'h7E, 0, 1, "R1");
        step(1, 24'h000010, 16'h0100, 16'h0, 16'h0, 16'hFF00, 8'h7E, 0, 1, "R2");
        step(1, 24'h000005, 16'h0, 16'h0003, 16'h0, 16'h2001, 8'h00, 1, 0, "R2");
        // Misaligned dp under non-direct modes: no penalty
        step(2, 24'h001234, 16'h0, 16'h0, 16'h0, 16'h00FF, 8'h05, 0, 1, "R3");
        step(6, 24'h000001, 16'h0, 16'h0, 16'h0100, 16'h0011, 8'h05, 0, 1, "R3");
        // Absolute ignores operand bank byte
        step(2, 24'hAB1234, 16'h0, 16'h0, 16'h0, 16'h0, 8'h05, 0, 1, "R4");
        // Absolute indexed carry into bank
        step(3, 24'h00FFFC, 16'h0008, 16'h0, 16'h0, 16'h0, 8'h01, 0, 1, "R5");
        step(3, 24'h00FFFF, 16'h0001, 16'h0, 16'h0, 16'h0, 8'hFF, 0, 1, "R5");
        // Long and long indexed wrap
        step(4, 24'h7F00AA, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00, 0, 1, "R6");
        step(5, 24'hFFFFFF, 16'h0002, 16'h0, 16'h0, 16'h0, 8'h00, 0, 1, "R7");
        // Stack relative with wrap
        step(6, 24'h000020, 16'h0, 16'h0, 16'h01F0, 16'h0, 8'h00, 0, 1, "R8");
        step(6, 24'h0000FF, 16'h0, 16'h0, 16'hFFF0, 16'h0, 8'h33, 0, 1, "R8");
        // Index source and width
        step(3, 24'h002000, 16'h1234, 16'h5678, 16'h0, 16'h0, 8'h01, 0, 0, "R9");
        step(3, 24'h002000, 16'h1234, 16'h5678, 16'h0, 16'h0, 8'h01, 0, 1, "R9");
        step(3, 24'h002000, 16'h1234, 16'h5678, 16'h0, 16'h0, 8'h01, 1, 0, "R9");
        step(5, 24'h002000, 16'h1234, 16'h5678, 16'h0, 16'h0, 8'h01, 1, 1, "R9");
        // Reserved code
        step(7, 24'h123456, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h00FF, 8'hFF, 0, 1, "R10");

        for (int i = 0; i < 3000; i++) begin
            int m;
            m = $urandom_range(0, 7);
            step(m, 24'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 (($urandom % 3) == 0) ? 16'($urandom) & 16'hFF00 : 16'($urandom),
                 8'($urandom), bit'($urandom % 2), bit'($urandom % 2), mode_tag(m));
        end

        // Reset clears outputs mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R10", ea_o, 24'h0);
        check("R10", {23'd0, extra_cyc_o}, 24'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule